// File: doc/BRIEF.md
# Serial Word Transmitter with Eight-Word Queue

This block takes 32-bit avionics serial words from a 16-bit host bus and sends them on a return-to-zero line. The line is driven as two separate logic outputs, one for ones and one for zeros. The host writes each word in two halves. A low-half strobe stages the lower 16 bits. A high-half strobe supplies the upper 16 bits and commits the whole word to an eight-word queue.

While the transmit enable is high, queued words go out one after another. The bit period is the master clock divided by 10 or by 80, and a control input picks which. Bit 32 of each word carries either an odd-parity bit or the host's own data bit. The choice is made from two control inputs at the moment the word is committed.

A ready output goes low when a word is accepted. It goes high again once the queue is empty and the last word, including its trailing null gap, is fully sent. A write to a full queue is dropped and sets a sticky overflow flag.

Top module: `a429_word_tx`

## Requirements
- R1: A pulse on `load_lo` stages `host_data` as bits 15:0 of a word. A later pulse on `load_hi` commits `{host_data, staged}` as one word. A `load_hi` pulse with no low half staged since the previous `load_hi` is ignored.
- R2: The queue holds up to 8 words, and words go out in the order they were committed.
- R3: A commit attempted while 8 words are queued is dropped and sets `overflow`. `overflow` is low after reset and stays high until the next reset.
- R4: With `slow_rate` low, a bit period is 10 clocks. With it high, a bit period is 80 clocks. The rate is sampled when a word starts and holds for that whole word.
- R5: In the first half of each bit period, `line_hi` is high for a 1 or `line_lo` is high for a 0. In the second half, both outputs are low. The two outputs are never high together, and both are low when nothing is being sent.
- R6: Word bit i (0-based) goes out in this order: bits 7 down to 0 first, then bits 8 up to 31.
- R7: If `par_force_n` is high or `par_en` is high at commit, bit 31 is replaced by odd parity, so the 32 bits hold an odd number of ones. If both are low, the host's bit 31 is sent unchanged.
- R8: A word starts only while `tx_en` is high. A word already started finishes even if `tx_en` falls.
- R9: Between the end of one word's last bit period and the first pulse of the next word, the line stays null for at least four bit periods.
- R10: `tx_ready` is high after reset and goes low in the cycle after a commit. It goes high again only when the queue is empty and the last word and its null gap are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| host_data | input | 16 | Host half-word data |
| load_lo | input | 1 | Strobe that stages the low half |
| load_hi | input | 1 | Strobe that supplies the high half and commits the word |
| par_en | input | 1 | Parity select for bit 32 when the override is low |
| par_force_n | input | 1 | Override; high forces parity into bit 32 |
| slow_rate | input | 1 | 0: clock/10 bit period, 1: clock/80 bit period |
| tx_en | input | 1 | Transmit enable |
| line_hi | output | 1 | Return-to-zero ONES output |
| line_lo | output | 1 | Return-to-zero ZEROS output |
| tx_ready | output | 1 | High when the queue and serializer are idle |
| overflow | output | 1 | Sticky flag for a write to a full queue |

## Verification
The assertions assume that `load_lo` and `load_hi` are never high in the same cycle. They also assume that `slow_rate` changes only while no word is on the line. The stimulus meets both assumptions: each write is a one-cycle low strobe followed by a one-cycle high strobe, and the rate is changed only after `tx_ready` has returned high. The checker's ready and overflow properties read the staged-half and queue-full state, so they cover both accepted and rejected commits. The scoreboard rebuilds every word from the line pulses and measures each pulse, each null half and each inter-word gap against the rate tagged on the expected word.

// File: rtl/a429_tx_pkg.sv
package a429_tx_pkg;

    localparam int WORD_W  = 32;
    localparam int HALF_W  = 16;
    localparam int LABEL_W = 8;

    typedef logic [WORD_W-1:0] tx_word_t;

    typedef struct packed {
        logic [HALF_W-1:0] upper;
        logic [HALF_W-1:0] lower;
    } word_halves_t;

    typedef enum logic [1:0] {
        SH_IDLE = 2'd0,
        SH_SEND = 2'd1,
        SH_GAP  = 2'd2
    } shift_state_t;

    // bit that makes the total count of ones odd
    function automatic logic odd_fill(input tx_word_t w);
        return ~(^w[WORD_W-2:0]);
    endfunction

    function automatic tx_word_t resolve_top_bit(input tx_word_t w, input logic use_par);
        tx_word_t r;
        r = w;
        if (use_par) r[WORD_W-1] = odd_fill(w);
        return r;
    endfunction

    // rearranged so that shifting out from bit 0 gives the line order
    function automatic tx_word_t line_order(input tx_word_t w);
        tx_word_t r;
        for (int k = 0; k < WORD_W; k++) begin
            if (k < LABEL_W) r[k] = w[LABEL_W-1-k];
            else             r[k] = w[k];
        end
        return r;
    endfunction

endpackage

// File: rtl/a429_half_loader.sv
module a429_half_loader
    import a429_tx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [HALF_W-1:0] host_data,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              par_en,
    input  logic              par_force_n,
    input  logic              fifo_full,
    output logic              commit,
    output tx_word_t          commit_word,
    output logic              lo_pending,
    output logic              overflow
);

    logic [HALF_W-1:0] lo_q;
    word_halves_t      joined;

    assign joined.upper = host_data;
    assign joined.lower = lo_q;

    assign commit      = load_hi & lo_pending & ~fifo_full;
    assign commit_word = resolve_top_bit(tx_word_t'(joined), par_force_n | par_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q       <= '0;
            lo_pending <= 1'b0;
            overflow   <= 1'b0;
        end else begin
            if (load_lo) begin
                lo_q       <= host_data;
                lo_pending <= 1'b1;
            end else if (load_hi) begin
                lo_pending <= 1'b0;
            end
            if (load_hi && lo_pending && fifo_full)
                overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/a429_word_fifo.sv
module a429_word_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_wr, do_rd;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_wr   = wr_en & ~full;
    assign do_rd   = rd_en & ~empty;
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= bump(wr_ptr);
            if (do_rd) rd_ptr <= bump(rd_ptr);
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/a429_bit_shifter.sv
module a429_bit_shifter
    import a429_tx_pkg::*;
#(
    parameter int DIV_FAST = 10,
    parameter int DIV_SLOW = 80,
    parameter int GAP_BITS = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tx_en,
    input  logic     slow_rate,
    input  logic     fifo_empty,
    input  tx_word_t head_word,
    output logic     pop,
    output logic     busy,
    output logic     line_hi,
    output logic     line_lo
);

    localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
    localparam int TICK_W  = $clog2(DIV_MAX + 1);
    localparam int BIT_W   = $clog2(WORD_W);
    localparam int GAP_W   = (GAP_BITS > 1) ? $clog2(GAP_BITS) : 1;

    shift_state_t      state;
    tx_word_t          shreg;
    logic [TICK_W-1:0] tick, div_q, half;
    logic [BIT_W-1:0]  bit_cnt;
    logic [GAP_W-1:0]  gap_cnt;
    logic              period_end, first_half;

    assign half       = div_q >> 1;
    assign period_end = (tick == div_q - 1'b1);
    assign first_half = (tick < half);
    assign pop        = (state == SH_IDLE) && tx_en && !fifo_empty;
    assign busy       = (state != SH_IDLE);
    assign line_hi    = (state == SH_SEND) && first_half &&  shreg[0];
    assign line_lo    = (state == SH_SEND) && first_half && !shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SH_IDLE;
            shreg   <= '0;
            tick    <= '0;
            div_q   <= TICK_W'(DIV_FAST);
            bit_cnt <= '0;
            gap_cnt <= '0;
        end else begin
            case (state)
                SH_IDLE: begin
                    if (pop) begin
                        shreg   <= line_order(head_word);
                        div_q   <= slow_rate ? TICK_W'(DIV_SLOW) : TICK_W'(DIV_FAST);
                        tick    <= '0;
                        bit_cnt <= '0;
                        state   <= SH_SEND;
                    end
                end
                SH_SEND: begin
                    if (period_end) begin
                        tick  <= '0;
                        shreg <= shreg >> 1;
                        if (bit_cnt == BIT_W'(WORD_W - 1)) begin
                            gap_cnt <= '0;
                            state   <= SH_GAP;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                SH_GAP: begin
                    if (period_end) begin
                        tick <= '0;
                        if (gap_cnt == GAP_W'(GAP_BITS - 1)) state <= SH_IDLE;
                        else gap_cnt <= gap_cnt + 1'b1;
                    end else begin
                        tick <= tick + 1'b1;
                    end
                end
                default: state <= SH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
    import a429_tx_pkg::*;
#(
    parameter int QUEUE_DEPTH = 8,
    parameter int DIV_FAST    = 10,
    parameter int DIV_SLOW    = 80,
    parameter int GAP_BITS    = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] host_data,
    input  logic        load_lo,
    input  logic        load_hi,
    input  logic        par_en,
    input  logic        par_force_n,
    input  logic        slow_rate,
    input  logic        tx_en,
    output logic        line_hi,
    output logic        line_lo,
    output logic        tx_ready,
    output logic        overflow
);

    logic     commit, lo_pending, fifo_full, fifo_empty, pop, busy;
    tx_word_t commit_word, head_word;

    a429_half_loader u_loader (
        .clk         (clk),
        .rst         (rst),
        .host_data   (host_data),
        .load_lo     (load_lo),
        .load_hi     (load_hi),
        .par_en      (par_en),
        .par_force_n (par_force_n),
        .fifo_full   (fifo_full),
        .commit      (commit),
        .commit_word (commit_word),
        .lo_pending  (lo_pending),
        .overflow    (overflow)
    );

    a429_word_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (QUEUE_DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (commit),
        .wr_data (commit_word),
        .rd_en   (pop),
        .rd_data (head_word),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    a429_bit_shifter #(
        .DIV_FAST (DIV_FAST),
        .DIV_SLOW (DIV_SLOW),
        .GAP_BITS (GAP_BITS)
    ) u_shift (
        .clk        (clk),
        .rst        (rst),
        .tx_en      (tx_en),
        .slow_rate  (slow_rate),
        .fifo_empty (fifo_empty),
        .head_word  (head_word),
        .pop        (pop),
        .busy       (busy),
        .line_hi    (line_hi),
        .line_lo    (line_lo)
    );

    always_ff @(posedge clk) begin
        if (rst)                         tx_ready <= 1'b1;
        else if (commit)                 tx_ready <= 1'b0;
        else if (fifo_empty && !busy)    tx_ready <= 1'b1;
    end

endmodule

// File: rtl/a429_tx_chk.sv
module a429_tx_chk (
    input logic clk,
    input logic rst,
    input logic load_hi,
    input logic tx_en,
    input logic tx_ready,
    input logic overflow,
    input logic line_hi,
    input logic line_lo,
    input logic lo_pending,
    input logic fifo_full,
    input logic busy
);

    // R5
    not_both_chk: assert property (@(posedge clk) disable iff (rst)
        !(line_hi && line_lo));

    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!line_hi && !line_lo));

    // R3
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R3
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (load_hi && lo_pending && fifo_full) |=> overflow);

    // R10
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (load_hi && lo_pending && !fifo_full) |=> !tx_ready);

    // R10
    ready_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> !tx_ready);

    // R1
    lone_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (load_hi && !lo_pending && tx_ready) |=> tx_ready);

    // R8
    start_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !tx_en) |=> !busy);

endmodule

bind a429_word_tx a429_tx_chk i_chk (.*);

// File: tb/test_a429_word_tx.sv
module test_a429_word_tx;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_data = '0;
    logic        load_lo = 1'b0, load_hi = 1'b0;
    logic        par_en = 1'b0, par_force_n = 1'b0;
    logic        slow_rate = 1'b0, tx_en = 1'b0;
    logic        line_hi, line_lo, tx_ready, overflow;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] w;
        int          div;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    a429_word_tx i_a429_word_tx (
        .clk(clk), .rst(rst), .host_data(host_data), .load_lo(load_lo),
        .load_hi(load_hi), .par_en(par_en), .par_force_n(par_force_n),
        .slow_rate(slow_rate), .tx_en(tx_en), .line_hi(line_hi),
        .line_lo(line_lo), .tx_ready(tx_ready), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(input logic [31:0] w, input bit pe, input bit fn);
        logic [31:0] r;
        r = w;
        if (fn || pe) r[31] = ~(^w[30:0]);
        return r;
    endfunction

    task automatic write_word(input logic [31:0] w, input bit pe, input bit fn,
                              input bit accept, input int div);
        exp_t e;
        @(negedge clk);
        host_data = w[15:0];
        load_lo   = 1'b1;
        @(negedge clk);
        load_lo     = 1'b0;
        host_data   = w[31:16];
        par_en      = pe;
        par_force_n = fn;
        load_hi     = 1'b1;
        @(negedge clk);
        load_hi = 1'b0;
        if (accept) begin
            e.w   = expect_word(w, pe, fn);
            e.div = div;
            sb.push_back(e);
        end
    endtask

    task automatic wait_ready();
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
    endtask

    // monitor: rebuilds words from pulses and pops the scoreboard
    int          run = 0, nb = 0, cur_div = 10, prev_div = 10, pulses = 0, words = 0;
    bit          prev_act = 1'b0, have_prev = 1'b0;
    logic        act;
    logic [31:0] got = '0;

    always @(negedge clk) begin
        if (rst) begin
            run = 0; nb = 0; prev_act = 1'b0; have_prev = 1'b0;
        end else begin
            act = line_hi | line_lo;
            if (act && !prev_act) begin
                pulses++;
                if (nb == 0) begin
                    cur_div = (sb.size() > 0) ? sb[0].div : 10;
                    // R9 null gap between words
                    if (have_prev)
                        check(run >= prev_div / 2 + 4 * prev_div, "R9", "gap cycles",
                              run, prev_div / 2 + 4 * prev_div);
                end else begin
                    // R5 null half inside a word
                    check(run == cur_div / 2, "R5", "null half cycles", run, cur_div / 2);
                end
                got[(nb < 8) ? (7 - nb) : nb] = line_hi;
                nb++;
                run = 1;
            end else if (act == prev_act) begin
                run++;
            end else begin
                // R4 pulse width follows the selected rate
                check(run == cur_div / 2, "R4", "pulse cycles", run, cur_div / 2);
                if (nb == 32) begin
                    words++;
                    if (sb.size() == 0) begin
                        check(1'b0, "R2", "unexpected word", got, '0);
                    end else begin
                        // R6 order, R7 bit 32, R1 halves, R2 ordering
                        check(got == sb[0].w, "R6/R7", "word", got, sb[0].w);
                        void'(sb.pop_front());
                    end
                    have_prev = 1'b1;
                    prev_div  = cur_div;
                    nb        = 0;
                end
                run = 1;
            end
            prev_act = act;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R10", "ready after reset", tx_ready, 1);
        check(overflow == 1'b0, "R3", "overflow after reset", overflow, 0);
        check(!line_hi && !line_lo, "R5", "idle line", {line_hi, line_lo}, 0);

        // R1 high strobe without a staged low half
        @(negedge clk);
        host_data = 16'hBEEF;
        load_hi   = 1'b1;
        @(negedge clk);
        load_hi = 1'b0;
        @(negedge clk);
        check(tx_ready == 1'b1, "R1", "lone high strobe ignored", tx_ready, 1);
        check(overflow == 1'b0, "R1", "lone strobe no overflow", overflow, 0);

        // queue while disabled, three parity modes
        write_word(32'h8123_45C1, 1'b0, 1'b1, 1'b1, 10);
        check(tx_ready == 1'b0, "R10", "ready low after commit", tx_ready, 0);
        write_word(32'h8000_0003, 1'b0, 1'b0, 1'b1, 10);
        write_word(32'h0F0F_A55A, 1'b1, 1'b0, 1'b1, 10);
        write_word(32'h7FFF_FF80, 1'b0, 1'b0, 1'b1, 10);
        p0 = pulses;
        repeat (300) @(negedge clk);
        check(pulses == p0, "R8", "no pulses while disabled", pulses, p0);
        check(tx_ready == 1'b0, "R10", "ready low with queue", tx_ready, 0);

        tx_en = 1'b1;
        wait_ready();
        check(sb.size() == 0, "R2", "all queued words sent", sb.size(), 0);
        check(words == 4, "R2", "word count", words, 4);

        // R4 slow rate
        slow_rate = 1'b1;
        write_word(32'h1234_5678, 1'b0, 1'b1, 1'b1, 80);
        wait_ready();
        slow_rate = 1'b0;
        check(sb.size() == 0, "R4", "slow word sent", sb.size(), 0);

        // R3 overflow on ninth word
        tx_en = 1'b0;
        for (int i = 0; i < 8; i++)
            write_word(32'hA000_0000 + 32'(i * 32'h0101_0011), i[0], 1'b0, 1'b1, 10);
        check(overflow == 1'b0, "R3", "no overflow at eight", overflow, 0);
        write_word(32'hDEAD_0009, 1'b0, 1'b0, 1'b0, 10);
        check(overflow == 1'b1, "R3", "overflow on ninth", overflow, 1);
        tx_en = 1'b1;
        wait_ready();
        check(sb.size() == 0, "R3", "ninth word dropped", sb.size(), 0);
        check(words == 13, "R2", "eight words delivered", words, 13);
        check(overflow == 1'b1, "R3", "overflow sticky", overflow, 1);

        // R8 enable drops mid-word, word completes
        write_word(32'h5A5A_3C3C, 1'b1, 1'b0, 1'b1, 10);
        repeat (60) @(negedge clk);
        tx_en = 1'b0;
        wait_ready();
        check(sb.size() == 0, "R8", "started word completes", sb.size(), 0);
        check(words == 14, "R8", "word count after drop", words, 14);
        check(tx_ready == 1'b1, "R10", "ready after drain", tx_ready, 1);

        repeat (20) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule